// File: doc/BRIEF.md
# Three-Level Thermal Shutdown Supervisor

This block watches a digital junction-temperature reading and protects four line-driver channels with three independent temperature levels. The lowest level stops new channel activation requests from being admitted. The middle level removes channels that are sitting in current limit. The top level removes every channel that is driving. Each level has its own trip point and its own lower release point, and each keeps its own tripped state, so the hysteresis bands work independently of one another.

For each channel the block keeps a latched permission bit. The bit is high when the channel may be driven and is latched low when a thermal trip removed that channel. Only the channel's own switch-off command or a reset sets it high again. A switch-off command only releases the latch once the level that caused it has released. The surrounding control logic uses the admission enable, the forced-off mask and the permission bits to decide which drivers may be switched on.

Top module: `tsup_top`

## Requirements
- R1: `admit_en` goes low one cycle after a sample with `temp_c` >= 110. It goes high again one cycle after a sample with `temp_c` < 100. For samples from 100 to 109 it keeps its previous value.
- R2: A sample with `temp_c` >= 130 and `ilim[i]` high drives `tor[i]` low on the next cycle. Bit i of every 4-bit port belongs to channel i, with bit 0 as the LSB.
- R3: A permission bit latched low by the 130 level is set high by `sw_off[i]` only when the sample is below 120 with `seq_en`=0, or below 100 with `seq_en`=1. A `sw_off[i]` given at higher temperatures is ignored and the bit stays low.
- R4: After a sample with `temp_c` >= 160, all four `tor` bits are low. They stay low until a sample below 150 arrives.
- R5: When the 160 level releases, `tor` returns high only for channels whose `drv_on` was low at every sample at or above 160 in that trip. The other channels stay latched low.
- R6: `sw_off[i]` affects only channel i. It releases both the 130 and the 160 latch of channel i, and each latch only once its own level has released.
- R7: If a trip event and `sw_off[i]` arrive for channel i in the same sample, the trip wins and `tor[i]` is low on the next cycle.
- R8: One cycle after a sample with `rst_n` low (synchronous reset), the outputs are `tor`=4'b1111, `force_off`=4'b0000, `admit_en`=1 and `t_hot`=0.
- R9: `t_hot` is 1 one cycle after a sample with `temp_c` > 160 and 0 otherwise. A value of exactly 160 gives 0.
- R10: `force_off` is always the bitwise inverse of `tor`. All outputs are registered and follow the sampled inputs with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_c | input | 8 | Junction temperature in degrees Celsius, unsigned |
| ilim | input | 4 | Per-channel flag: the channel is in current limit |
| drv_on | input | 4 | Per-channel flag: the driver is currently on |
| sw_off | input | 4 | Per-channel switch-off command, releases that channel's latch |
| seq_en | input | 1 | Power-on sequencer enabled; moves the 130 level's release point to 100 |
| admit_en | output | 1 | New activation requests may be admitted |
| force_off | output | 4 | Per-channel mask of drivers that must be off |
| tor | output | 4 | Per-channel permission bits, high = channel may be driven |
| t_hot | output | 1 | Temperature above 160 |

## Verification
Every result of this block is due exactly one clock edge after the input sample that causes it: a threshold crossing, a current-limit trip, a switch-off release and a reset all show on the ports after a single register stage. The bench changes inputs at the falling edge, lets one rising edge pass and compares at the following falling edge, so each comparison sees the response to exactly one sample. Hysteresis and latch cases are built by chaining samples in the table, so the held state from one row is checked through the expected value of the next.

// File: rtl/tsup_pkg.sv
package tsup_pkg;

    localparam int NCH_DEF = 4;
    localparam int TW_DEF  = 8;

    // default thermal points in degrees Celsius
    localparam int ADMIT_TRIP_DEF   = 110;
    localparam int ADMIT_REL_DEF    = 100;
    localparam int LIMIT_TRIP_DEF   = 130;
    localparam int LIMIT_REL_DEF    = 120;
    localparam int LIMIT_REL_SEQ_DEF = 100;
    localparam int HOT_TRIP_DEF     = 160;
    localparam int HOT_REL_DEF      = 150;

    // next state of one hysteresis level
    typedef enum logic {
        LVL_CLEAR   = 1'b0,
        LVL_TRIPPED = 1'b1
    } lvl_state_e;

    // combined view of the three levels
    typedef struct packed {
        lvl_state_e admit;
        lvl_state_e limit;
        lvl_state_e hot;
    } lvl_vec_t;

    function automatic lvl_state_e lvl_next(
        input logic       at_trip,
        input logic       below_rel,
        input lvl_state_e cur
    );
        if (at_trip)
            return LVL_TRIPPED;
        else if (below_rel)
            return LVL_CLEAR;
        else
            return cur;
    endfunction

endpackage

// File: rtl/tsup_level.sv
module tsup_level
    import tsup_pkg::*;
#(
    parameter int TW   = TW_DEF,
    parameter int TRIP = ADMIT_TRIP_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_i,
    input  logic [TW-1:0] rel_i,
    output lvl_state_e    state_next_o,
    output lvl_state_e    state_o
);
    localparam logic [TW-1:0] TRIP_V = TW'(TRIP);

    lvl_state_e state_q;

    always_comb begin
        state_next_o = lvl_next(temp_i >= TRIP_V, temp_i < rel_i, state_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LVL_CLEAR;
        else
            state_q <= state_next_o;
    end

    assign state_o = state_q;

    // R1
    lvl_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i >= TRIP_V) |=> (state_q == LVL_TRIPPED));

    // R3
    lvl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i < rel_i && temp_i < TRIP_V) |=> (state_q == LVL_CLEAR));

endmodule

// File: rtl/tsup_chan.sv
module tsup_chan
    import tsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic limit_ev_i,
    input  logic hot_ev_i,
    input  logic sw_off_i,
    input  logic limit_clear_ok_i,
    input  logic hot_clear_ok_i,
    output logic held_next_o
);
    logic limit_q, hot_q;
    logic limit_n, hot_n;

    always_comb begin
        limit_n     = limit_ev_i | (limit_q & ~(sw_off_i & limit_clear_ok_i));
        hot_n       = hot_ev_i   | (hot_q   & ~(sw_off_i & hot_clear_ok_i));
        held_next_o = limit_n | hot_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= 1'b0;
            hot_q   <= 1'b0;
        end else begin
            limit_q <= limit_n;
            hot_q   <= hot_n;
        end
    end

    // R6
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_q && !sw_off_i) |=> limit_q);

    // R6
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_q && !sw_off_i) |=> hot_q);

    // R7
    trip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_ev_i || hot_ev_i) |=> (limit_q || hot_q));

endmodule

// File: rtl/tsup_top.sv
module tsup_top
    import tsup_pkg::*;
#(
    parameter int NCH           = NCH_DEF,
    parameter int TW            = TW_DEF,
    parameter int ADMIT_TRIP    = ADMIT_TRIP_DEF,
    parameter int ADMIT_REL     = ADMIT_REL_DEF,
    parameter int LIMIT_TRIP    = LIMIT_TRIP_DEF,
    parameter int LIMIT_REL     = LIMIT_REL_DEF,
    parameter int LIMIT_REL_SEQ = LIMIT_REL_SEQ_DEF,
    parameter int HOT_TRIP      = HOT_TRIP_DEF,
    parameter int HOT_REL       = HOT_REL_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  temp_c,
    input  logic [NCH-1:0] ilim,
    input  logic [NCH-1:0] drv_on,
    input  logic [NCH-1:0] sw_off,
    input  logic           seq_en,
    output logic           admit_en,
    output logic [NCH-1:0] force_off,
    output logic [NCH-1:0] tor,
    output logic           t_hot
);
    localparam logic [TW-1:0] ADMIT_REL_V     = TW'(ADMIT_REL);
    localparam logic [TW-1:0] LIMIT_REL_V     = TW'(LIMIT_REL);
    localparam logic [TW-1:0] LIMIT_REL_SEQ_V = TW'(LIMIT_REL_SEQ);
    localparam logic [TW-1:0] HOT_REL_V       = TW'(HOT_REL);
    localparam logic [TW-1:0] LIMIT_TRIP_V    = TW'(LIMIT_TRIP);
    localparam logic [TW-1:0] HOT_TRIP_V      = TW'(HOT_TRIP);

    lvl_vec_t       lvl_n, lvl_q;
    logic [TW-1:0]  limit_rel;
    logic [NCH-1:0] held_n;
    logic [NCH-1:0] tor_n;

    assign limit_rel = seq_en ? LIMIT_REL_SEQ_V : LIMIT_REL_V;

    tsup_level #(.TW(TW), .TRIP(ADMIT_TRIP)) u_admit (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_c), .rel_i(ADMIT_REL_V),
        .state_next_o(lvl_n.admit), .state_o(lvl_q.admit)
    );

    tsup_level #(.TW(TW), .TRIP(LIMIT_TRIP)) u_limit (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_c), .rel_i(limit_rel),
        .state_next_o(lvl_n.limit), .state_o(lvl_q.limit)
    );

    tsup_level #(.TW(TW), .TRIP(HOT_TRIP)) u_hot (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_c), .rel_i(HOT_REL_V),
        .state_next_o(lvl_n.hot), .state_o(lvl_q.hot)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tsup_chan u_chan (
            .clk              (clk),
            .rst_n            (rst_n),
            .limit_ev_i       ((temp_c >= LIMIT_TRIP_V) & ilim[c]),
            .hot_ev_i         ((temp_c >= HOT_TRIP_V) & drv_on[c]),
            .sw_off_i         (sw_off[c]),
            .limit_clear_ok_i (lvl_n.limit == LVL_CLEAR),
            .hot_clear_ok_i   (lvl_n.hot == LVL_CLEAR),
            .held_next_o      (held_n[c])
        );
    end

    always_comb begin
        tor_n = ~held_n & {NCH{lvl_n.hot == LVL_CLEAR}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            admit_en  <= 1'b1;
            tor       <= '1;
            force_off <= '0;
            t_hot     <= 1'b0;
        end else begin
            admit_en  <= (lvl_n.admit == LVL_CLEAR);
            tor       <= tor_n;
            force_off <= ~tor_n;
            t_hot     <= (temp_c > HOT_TRIP_V);
        end
    end

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (tor == '1 && force_off == '0 && admit_en && !t_hot));

    // R4
    hot_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_hot |-> (tor == '0));

    // R2
    limit_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c >= LIMIT_TRIP_V) |=> ((tor & $past(ilim)) == '0));

    // R1
    admit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q.admit == LVL_TRIPPED) |-> !admit_en);

endmodule

// File: tb/tsup_top_tb.sv
module tsup_top_tb_top;

    typedef struct packed {
        logic [7:0] temp;
        logic [3:0] ilim;
        logic [3:0] drv;
        logic [3:0] sw;
        logic       seq;
        logic       e_admit;
        logic [3:0] e_tor;
        logic       e_hot;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{8'd25,  4'h0, 4'hF, 4'h0, 1'b0, 1'b1, 4'hF, 1'b0}, // R1 cool
        '{8'd110, 4'h0, 4'hF, 4'h0, 1'b0, 1'b0, 4'hF, 1'b0}, // R1 trip
        '{8'd105, 4'h0, 4'hF, 4'h0, 1'b0, 1'b0, 4'hF, 1'b0}, // R1 hold
        '{8'd99,  4'h0, 4'hF, 4'h0, 1'b0, 1'b1, 4'hF, 1'b0}, // R1 release
        '{8'd130, 4'h1, 4'hF, 4'h0, 1'b0, 1'b0, 4'hE, 1'b0}, // R2 ch0
        '{8'd125, 4'h0, 4'hF, 4'h1, 1'b0, 1'b0, 4'hE, 1'b0}, // R3 early sw ignored
        '{8'd119, 4'h0, 4'hF, 4'h1, 1'b0, 1'b0, 4'hF, 1'b0}, // R3 release <120
        '{8'd130, 4'h2, 4'hF, 4'h0, 1'b0, 1'b0, 4'hD, 1'b0}, // R2 ch1
        '{8'd110, 4'h0, 4'hF, 4'h2, 1'b1, 1'b0, 4'hD, 1'b0}, // R3 seq: 110 holds
        '{8'd99,  4'h0, 4'hF, 4'h2, 1'b1, 1'b1, 4'hF, 1'b0}, // R3 seq release
        '{8'd160, 4'h0, 4'h5, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0}, // R4 R9 160 exact
        '{8'd161, 4'h0, 4'h5, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1}, // R9 above 160
        '{8'd155, 4'h0, 4'h0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0}, // R4 band hold
        '{8'd140, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'hA, 1'b0}, // R5 latched only driven
        '{8'd140, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 4'hB, 1'b0}, // R6 ch0 only
        '{8'd140, 4'h0, 4'h0, 4'h4, 1'b0, 1'b0, 4'hF, 1'b0}  // R6 ch2 only
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] temp_c;
    logic [3:0] ilim, drv_on, sw_off;
    logic       seq_en;
    logic       admit_en, t_hot;
    logic [3:0] force_off, tor;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tsup_top dut_i (
        .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .ilim(ilim),
        .drv_on(drv_on), .sw_off(sw_off), .seq_en(seq_en),
        .admit_en(admit_en), .force_off(force_off), .tor(tor), .t_hot(t_hot)
    );

    task automatic drive(input logic [7:0] t, input logic [3:0] il,
                         input logic [3:0] dv, input logic [3:0] so, input logic sq);
        temp_c = t; ilim = il; drv_on = dv; sw_off = so; seq_en = sq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic ea,
                         input logic [3:0] et, input logic eh);
        n_chk++;
        if (admit_en !== ea || tor !== et || force_off !== ~et || t_hot !== eh) begin
            n_bad++;
            $display("FAIL %s: admit=%b tor=%h force=%h hot=%b expected admit=%b tor=%h force=%h hot=%b",
                     req, admit_en, tor, force_off, t_hot, ea, et, ~et, eh);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        temp_c = 8'd25; ilim = '0; drv_on = '0; sw_off = '0; seq_en = 1'b0;
        @(negedge clk);
        drive(8'd25, 4'h0, 4'h0, 4'h0, 1'b0);
        check("R8 reset", 1'b1, 4'hF, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].temp, VEC[i].ilim, VEC[i].drv, VEC[i].sw, VEC[i].seq);
            check($sformatf("R10 vector %0d", i), VEC[i].e_admit, VEC[i].e_tor, VEC[i].e_hot);
        end

        // R7: trip and release in the same sample
        drive(8'd130, 4'h1, 4'h0, 4'h1, 1'b0);
        check("R7 trip beats sw_off", 1'b0, 4'hE, 1'b0);
        drive(8'd25, 4'h0, 4'h0, 4'h1, 1'b0);
        check("R3 release after cool", 1'b1, 4'hF, 1'b0);

        // R8: reset in the middle of a hot trip
        drive(8'd200, 4'hF, 4'hF, 4'h0, 1'b0);
        check("R4 all low at 200", 1'b0, 4'h0, 1'b1);
        rst_n = 1'b0;
        drive(8'd25, 4'h0, 4'h0, 4'h0, 1'b0);
        check("R8 reset mid trip", 1'b1, 4'hF, 1'b0);
        rst_n = 1'b1;
        drive(8'd25, 4'h0, 4'h0, 4'h0, 1'b0);
        check("R8 latches cleared", 1'b1, 4'hF, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule